// File: doc/BRIEF.md
# Write-Through Invalidate Snooping Cache Controller

This block is the cache controller one node uses to keep a small direct-mapped data cache coherent with its peers. The cache is write-through, so it never holds data that memory lacks. Coherence comes from watching the shared bus. The bus is atomic: one transaction ends before the next one starts. Each line holds one word and is either valid or invalid.

The processor raises a request and holds its address, write flag and write data steady until the controller pulses done. A read that hits returns data at once. A read that misses asks for the bus, waits for the memory reply, fills the line and returns the reply word. Every write, hit or miss, goes to the bus. A write that hits also updates the cached word. A write that misses leaves the cache unchanged.

A separate observe port shows every bus transaction, including the node's own. A write from another node that matches a resident line clears that line. Transactions that carry this node's requester ID are ignored. Bus reads from any node are ignored.

Top module: `wtsnoop_cache`

## Requirements
- R1: After reset every line is invalid, busReq is low, and the first read of each index goes to the bus.
- R2: A read that hits raises cpuDone in the same cycle as the request, with cpuRdata equal to the cached word and no bus request.
- R3: A read that misses raises busReq with busWr=0 and busAddr=cpuAddr on the next cycle. One cycle after busGnt the controller waits for busRdValid. In that cycle it raises cpuDone with cpuRdata=busRdData and fills the line, so the next read of that address hits.
- R4: Every write raises busReq with busWr=1, busAddr=cpuAddr, busWdata=cpuWdata and busId=NODE_ID on the cycle after the request. cpuDone rises in the cycle busGnt is high, and never earlier.
- R5: A write that hits updates the cached word, so a later read hit returns the written value.
- R6: A write that misses does not allocate a line, so a later read of that address goes to the bus.
- R7: An observed transaction with snpWr=1 and snpId different from NODE_ID, whose address matches a valid line, invalidates that line.
- R8: Observed transactions whose snpId equals NODE_ID change no line state.
- R9: Observed bus reads (snpWr=0) change no line state.
- R10: An observed foreign write to an address with the same index but a different tag leaves the resident line valid.
- R11: When a foreign write invalidates the line being read in the same cycle, the invalidation takes effect first. The read is then treated as a miss.
- R12: While busReq is high and busGnt is low, busReq, busWr and busAddr hold their values into the next cycle.

Address split: the low IDX_W bits of an address are the index. The rest are the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuReq | input | 1 | Processor request, held until cpuDone |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Processor word address |
| cpuWdata | input | DATA_W | Processor write data |
| cpuRdata | output | DATA_W | Read data, valid with cpuDone on a read |
| cpuDone | output | 1 | Request completes this cycle |
| busReq | output | 1 | Request for the shared bus |
| busGnt | input | 1 | Bus granted; the transaction happens this cycle |
| busWr | output | 1 | Bus transaction is a write |
| busAddr | output | ADDR_W | Bus address |
| busWdata | output | DATA_W | Bus write data |
| busId | output | ID_W | Requester ID of this node |
| busRdValid | input | 1 | Memory reply for this node's read |
| busRdData | input | DATA_W | Memory reply data |
| snpValid | input | 1 | An observed bus transaction is present |
| snpWr | input | 1 | Observed transaction is a write |
| snpAddr | input | ADDR_W | Observed address |
| snpId | input | ID_W | Requester ID of the observed transaction |

## Verification
The hardest case to reach is a foreign invalidation that lands in the same cycle as a processor read of that very line. It needs the observe port and the request port driven together while the line is known to be resident. The bench first makes the line resident with a fill and then issues the read and the foreign write on the same clock. It also repeats the same-cycle case with the node's own ID, where the read must still hit. Beyond these directed cases, a long mixed sequence over a few tags per index drives reads, writes and observed traffic against a reference model of memory and line state.

// File: rtl/wtsnoop_pkg.sv
package wtsnoop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RDREQ  = 2'd1,
    ST_RDWAIT = 2'd2,
    ST_WRREQ  = 2'd3
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fill;    // load line from bus reply
    logic wrThru;  // write granted on bus; update word if resident
  } ctrlStrobe_t;

endpackage

// File: rtl/wtsnoop_datapath.sv
module wtsnoop_datapath
  import wtsnoop_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 2,
  parameter int ID_W    = 2,
  parameter int NODE_ID = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] busRdData,
  input  logic              snpValid,
  input  logic              snpWr,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [ID_W-1:0]   snpId,
  output logic              hit,
  output logic [DATA_W-1:0] rdData
);

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  validQ;
  logic [TAG_W-1:0]  tagQ  [LINES];
  logic [DATA_W-1:0] dataQ [LINES];

  logic [IDX_W-1:0] cpuIdx, snpIdx;
  logic [TAG_W-1:0] cpuTag, snpTag;
  logic             foreignWr;
  logic [LINES-1:0] killVec;
  logic [LINES-1:0] validEff;

  assign cpuIdx    = cpuAddr[IDX_W-1:0];
  assign cpuTag    = cpuAddr[ADDR_W-1:IDX_W];
  assign snpIdx    = snpAddr[IDX_W-1:0];
  assign snpTag    = snpAddr[ADDR_W-1:IDX_W];
  assign foreignWr = snpValid && snpWr && (snpId != ID_W'(NODE_ID));

  // per-line snoop compare
  for (genvar g = 0; g < LINES; g++) begin : g_snoop
    assign killVec[g] = foreignWr && (snpIdx == IDX_W'(g)) &&
                        validQ[g] && (tagQ[g] == snpTag);
  end

  // snoop applied before the processor lookup
  assign validEff = validQ & ~killVec;
  assign hit      = validEff[cpuIdx] && (tagQ[cpuIdx] == cpuTag);
  assign rdData   = strobe.fill ? busRdData : dataQ[cpuIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (strobe.fill && (cpuIdx == IDX_W'(i))) validQ[i] <= 1'b1;
        else if (killVec[i])                      validQ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      tagQ[cpuIdx]  <= cpuTag;
      dataQ[cpuIdx] <= busRdData;
    end else if (strobe.wrThru && hit) begin
      dataQ[cpuIdx] <= cpuWdata;
    end
  end

  AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |=> validQ[$past(cpuIdx)]); // R3

  AST_FOREIGN_KILL: assert property (@(posedge clk) disable iff (!rstN)
    (killVec[snpIdx] && !(strobe.fill && cpuIdx == snpIdx)) |=> !validQ[$past(snpIdx)]); // R7

  AST_OWN_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpId == ID_W'(NODE_ID) && validQ[snpIdx]) |=> validQ[$past(snpIdx)]); // R8

  AST_WRMISS_NOALLOC: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrThru && !validEff[cpuIdx]) |=> !validQ[$past(cpuIdx)]); // R6

endmodule

// File: rtl/wtsnoop_ctrl.sv
module wtsnoop_ctrl
  import wtsnoop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWe,
  input  logic        hit,
  input  logic        busGnt,
  input  logic        busRdValid,
  output ctrlStrobe_t strobe,
  output logic        cpuDone,
  output logic        busReq,
  output logic        busWr
);

  ctrlState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD  = stateQ;
    strobe  = '0;
    cpuDone = 1'b0;
    busReq  = 1'b0;
    busWr   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (cpuReq) begin
          if (cpuWe)    stateD  = ST_WRREQ;
          else if (hit) cpuDone = 1'b1;
          else          stateD  = ST_RDREQ;
        end
      end
      ST_RDREQ: begin
        busReq = 1'b1;
        if (busGnt) stateD = ST_RDWAIT;
      end
      ST_RDWAIT: begin
        if (busRdValid) begin
          strobe.fill = 1'b1;
          cpuDone     = 1'b1;
          stateD      = ST_IDLE;
        end
      end
      ST_WRREQ: begin
        busReq = 1'b1;
        busWr  = 1'b1;
        if (busGnt) begin
          strobe.wrThru = 1'b1;
          cpuDone       = 1'b1;
          stateD        = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt) |=> (busReq && busWr == $past(busWr))); // R12

  AST_WR_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (cpuDone && cpuWe) |-> (busGnt && busWr)); // R4

  AST_HIT_NO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (cpuDone && !cpuWe && !busRdValid) |-> !busReq); // R2

endmodule

// File: rtl/wtsnoop_cache.sv
module wtsnoop_cache
  import wtsnoop_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 2,
  parameter int ID_W    = 2,
  parameter int NODE_ID = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuDone,
  output logic              busReq,
  input  logic              busGnt,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic [ID_W-1:0]   busId,
  input  logic              busRdValid,
  input  logic [DATA_W-1:0] busRdData,
  input  logic              snpValid,
  input  logic              snpWr,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [ID_W-1:0]   snpId
);

  ctrlStrobe_t strobe;
  logic        hit;

  assign busAddr  = cpuAddr;
  assign busWdata = cpuWdata;
  assign busId    = ID_W'(NODE_ID);

  wtsnoop_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cpuReq     (cpuReq),
    .cpuWe      (cpuWe),
    .hit        (hit),
    .busGnt     (busGnt),
    .busRdValid (busRdValid),
    .strobe     (strobe),
    .cpuDone    (cpuDone),
    .busReq     (busReq),
    .busWr      (busWr)
  );

  wtsnoop_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .IDX_W   (IDX_W),
    .ID_W    (ID_W),
    .NODE_ID (NODE_ID)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .cpuAddr   (cpuAddr),
    .cpuWdata  (cpuWdata),
    .strobe    (strobe),
    .busRdData (busRdData),
    .snpValid  (snpValid),
    .snpWr     (snpWr),
    .snpAddr   (snpAddr),
    .snpId     (snpId),
    .hit       (hit),
    .rdData    (cpuRdata)
  );

endmodule

// File: tb/test_wtsnoop_cache.sv
module test_wtsnoop_cache;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6, DW = 16, IW = 2, IDW = 2, NODE = 1;
  localparam int TW = AW - IW;
  localparam int NADDR = 1 << AW, NLINE = 1 << IW;

  logic clk = 1'b0, rstN = 1'b0;
  logic cpuReq = 0, cpuWe = 0, busGnt = 0, busRdValid = 0;
  logic snpValid = 0, snpWr = 0;
  logic [AW-1:0] cpuAddr = '0, snpAddr = '0;
  logic [DW-1:0] cpuWdata = '0, busRdData = '0;
  logic [IDW-1:0] snpId = '0;
  logic [DW-1:0] cpuRdata, busWdata;
  logic cpuDone, busReq, busWr;
  logic [AW-1:0] busAddr;
  logic [IDW-1:0] busId;

  always #(CLK_PERIOD/2) clk = ~clk;

  wtsnoop_cache #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .ID_W(IDW), .NODE_ID(NODE)) i_wtsnoop_cache (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuDone(cpuDone), .busReq(busReq),
    .busGnt(busGnt), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata), .busId(busId),
    .busRdValid(busRdValid), .busRdData(busRdData), .snpValid(snpValid), .snpWr(snpWr),
    .snpAddr(snpAddr), .snpId(snpId));

  int checks = 0, fails = 0;
  logic [DW-1:0] mem [NADDR];
  bit mv [NLINE];
  logic [TW-1:0] mt [NLINE];
  bit sameSnp = 0;
  logic [AW-1:0] sameAddr = '0;
  logic [IDW-1:0] sameId = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit modelHit(input logic [AW-1:0] a);
    return mv[a[IW-1:0]] && (mt[a[IW-1:0]] == a[AW-1:IW]);
  endfunction

  task automatic doRead(input logic [AW-1:0] a, input string tagHit, input string tagMiss);
    bit expHit, bus;
    logic [DW-1:0] got;
    got = '0;
    @(negedge clk);
    cpuReq = 1; cpuWe = 0; cpuAddr = a;
    if (sameSnp) begin
      snpValid = 1; snpWr = 1; snpAddr = sameAddr; snpId = sameId;
      if (sameId != IDW'(NODE) && modelHit(sameAddr)) mv[sameAddr[IW-1:0]] = 0;
    end
    expHit = modelHit(a);
    #1;
    bus = !cpuDone;
    if (cpuDone) got = cpuRdata;
    check(bus == !expHit, expHit ? tagHit : tagMiss, "bus use on read", bus, !expHit);
    if (!bus) check(!busReq, tagHit, "busReq on hit", busReq, 0);
    @(negedge clk);
    snpValid = 0; sameSnp = 0;
    if (bus) begin
      #1;
      check(busReq && !busWr && busAddr == a, tagMiss, "bus read request",
            {busReq, busWr, busAddr}, {1'b1, 1'b0, a});
      @(negedge clk); #1;
      check(busReq && !busWr && busAddr == a, "R12", "request held without grant",
            {busReq, busWr, busAddr}, {1'b1, 1'b0, a});
      busGnt = 1;
      @(negedge clk);
      busGnt = 0; busRdValid = 1; busRdData = mem[a];
      #1;
      check(cpuDone, "R3", "done with reply", cpuDone, 1);
      got = cpuRdata;
      @(negedge clk);
      busRdValid = 0;
      mv[a[IW-1:0]] = 1; mt[a[IW-1:0]] = a[AW-1:IW];
    end
    cpuReq = 0;
    check(got == mem[a], expHit ? tagHit : tagMiss, "read data", got, mem[a]);
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cpuReq = 1; cpuWe = 1; cpuAddr = a; cpuWdata = d;
    #1;
    check(!cpuDone && !busReq, "R4", "no done before bus", {cpuDone, busReq}, 0);
    @(negedge clk); #1;
    check(busReq && busWr && busAddr == a && busWdata == d && busId == IDW'(NODE), "R4",
          "bus write fields", {busReq, busWr, busAddr, busWdata, busId},
          {1'b1, 1'b1, a, d, IDW'(NODE)});
    busGnt = 1;
    #1;
    check(cpuDone, "R4", "done at grant", cpuDone, 1);
    @(negedge clk);
    busGnt = 0; cpuReq = 0; cpuWe = 0;
    mem[a] = d;
  endtask

  task automatic doSnoop(input logic [AW-1:0] a, input bit wr, input logic [IDW-1:0] id,
                         input logic [DW-1:0] d);
    @(negedge clk);
    snpValid = 1; snpWr = wr; snpAddr = a; snpId = id;
    if (wr && id != IDW'(NODE)) begin
      mem[a] = d;
      if (modelHit(a)) mv[a[IW-1:0]] = 0;
    end
    @(negedge clk);
    snpValid = 0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NADDR; i++) mem[i] = DW'(i * 37 + 5);
    for (int i = 0; i < NLINE; i++) begin mv[i] = 0; mt[i] = '0; end
    repeat (3) @(negedge clk);
    #1;
    check(!busReq && !cpuDone, "R1", "reset outputs", {busReq, cpuDone}, 0);
    rstN = 1;

    // sweep every address: cold miss then hit
    for (int a = 0; a < NADDR; a++) begin
      doRead(AW'(a), "R2", (a < NLINE) ? "R1" : "R3");
      doRead(AW'(a), "R2", "R3");
    end

    // write misses (lines hold tag 15), then write hits
    for (int a = 0; a < 16; a++) doWrite(AW'(a), DW'(a * 3 + 100));
    for (int a = 60; a < 64; a++) doWrite(AW'(a), DW'(a * 5 + 7));
    for (int a = 0; a < 16; a++) doRead(AW'(a), "R6", "R6");
    for (int a = 60; a < 64; a++) doWrite(AW'(a), DW'(a * 11 + 1));
    for (int a = 60; a < 64; a++) doRead(AW'(a), "R5", "R5");

    // observed traffic
    doSnoop(AW'(61), 1, 2'd0, 16'h1234);
    doRead(AW'(61), "R7", "R7");
    doSnoop(AW'(2), 1, 2'd3, 16'h4321);
    doRead(AW'(62), "R10", "R10");
    doSnoop(AW'(63), 0, 2'd2, 16'h0);
    doRead(AW'(63), "R9", "R9");
    doSnoop(AW'(60), 1, IDW'(NODE), 16'h0);
    doRead(AW'(60), "R8", "R8");

    // same-cycle snoop and read of the same line
    doRead(AW'(60), "R2", "R2");
    sameSnp = 1; sameAddr = AW'(60); sameId = 2'd2;
    doRead(AW'(60), "R11", "R11");
    sameSnp = 1; sameAddr = AW'(60); sameId = IDW'(NODE);
    doRead(AW'(60), "R8", "R8");

    // mixed sequence over four tags per index
    for (int n = 0; n < 1200; n++) begin
      logic [AW-1:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = AW'(lfsr[7:4]);
      case (lfsr[2:0])
        3'd0, 3'd1, 3'd2, 3'd3: doRead(a, "R2/R5/R8/R9/R10", "R3/R6/R7");
        3'd4: doWrite(a, lfsr);
        3'd5: doSnoop(a, 1, (lfsr[8] ? 2'd0 : 2'd3), ~lfsr);
        3'd6: doSnoop(a, 1, IDW'(NODE), 16'h0);
        default: doSnoop(a, 0, 2'd2, 16'h0);
      endcase
      if (lfsr[3] && lfsr[9]) begin
        sameSnp = 1; sameAddr = a; sameId = lfsr[11] ? 2'd0 : IDW'(NODE);
        if (lfsr[11]) mem[a] = ~mem[a];
        doRead(a, "R8", "R11");
      end
    end

    finishRun();
  end
endmodule